// File: doc/BRIEF.md
# Transmit Descriptor and Status Ring Engine

This block is the queue manager on the transmit side of a bus-mastering Ethernet controller. Software fills descriptors in an eight-entry ring and tells the block how many are new by pulsing an enqueue strobe with a count. While transmission and transmit DMA are both enabled and work is pending, the block reads the next descriptor through a memory read port and hands its buffer address, length and end-of-frame flag to a transmit core. It then waits for the core's completion result.

A descriptor whose abort flag is set is not handed to the core. For every descriptor, sent or aborted, the block writes one status word into the matching slot of a parallel status ring. Each status write sets a transmit interrupt status bit, and that bit is gated by an enable input. The ring pointer wraps modulo the ring size. The pending count saturates at the ring size, and an enqueue that would exceed it sets a sticky error flag.

Top module: `tx_ring_engine`

## Requirements
- R1: `pending` increases by `enq_cnt` on each cycle with `enq_we` high and decreases by one on each status write. When both happen in the same cycle, both are applied.
- R2: `pending` never exceeds 8. An enqueue that would take it past 8 leaves it at 8 and sets `ovf_err`, which then stays high until reset.
- R3: `desc_rd` is asserted only while `tx_en` and `dma_en` are both high and `pending` is non-zero. While either enable is low, pending work stays queued.
- R4: For a descriptor that is sent, the block raises `core_start` for exactly one cycle. In that cycle `core_buf_addr` carries the descriptor's address word, `core_len` carries control bits 11:0 and `core_eof` carries control bit 31.
- R5: The status word is laid out as follows:
  - bit 31: always 1 (processed).
  - bit 30: the core reported success.
  - bit 29: frame aborted.
  - bit 28: loss of carrier.
  - bit 26: late collision.
  - bit 25: underrun.
  - bit 24: excess collisions.
  - bits 20:16: collision count.
  - bits 14:0: the descriptor's index field (control bits 30:16).
  - bits 27, 23:21 and 15: zero.
- R6: A descriptor with control bit 15 set produces no `core_start`. Its status has bits 31 and 29 set, bit 30 clear, all cause and count bits zero, and the echoed index.
- R7: Status words are written one per descriptor and in descriptor order. Each goes to the slot it was read from, and slots wrap from 7 back to 0.
- R8: Each status write sets the interrupt status, and `irq` equals that status ANDed with `irq_en`. `irq_clr` clears the status, but a status write in the same cycle wins.
- R9: After reset, `pending` is 0, `ovf_err` and `irq` are 0, and neither `desc_rd` nor `st_we` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| dma_en | input | 1 | Transmit DMA enable |
| enq_we | input | 1 | Enqueue strobe |
| enq_cnt | input | 4 | Number of descriptors added |
| desc_rd | output | 1 | Descriptor read request |
| desc_addr | output | 3 | Descriptor slot to read |
| desc_rdata_addr | input | 32 | Buffer address word, valid the cycle after the request |
| desc_rdata_ctl | input | 32 | Control word, valid the cycle after the request |
| core_start | output | 1 | Start pulse to the transmit core |
| core_buf_addr | output | 32 | Buffer address to send |
| core_len | output | 12 | Frame length |
| core_eof | output | 1 | End-of-frame flag |
| core_done | input | 1 | Completion pulse from the core |
| core_ok | input | 1 | Sent without error |
| core_lcrs | input | 1 | Loss of carrier |
| core_ow | input | 1 | Late collision |
| core_txu | input | 1 | Underrun |
| core_ecoll | input | 1 | Excess collisions |
| core_ncoll | input | 5 | Collision count |
| st_we | output | 1 | Status ring write strobe |
| st_addr | output | 3 | Status slot |
| st_wdata | output | 32 | Status word |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Interrupt status clear |
| irq | output | 1 | Transmit interrupt |
| pending | output | 4 | Descriptors awaiting completion |
| ovf_err | output | 1 | Sticky enqueue overflow flag |

## Verification
A completion, which decrements the pending count and sets the interrupt, can fall in the same cycle as an enqueue or an interrupt clear from software. The bench waits for the cycle in which `st_we` is high and drives `enq_we` and, on a later completion, `irq_clr` in exactly that cycle. It then expects `pending` to show the sum and difference together, and `irq` to stay set. A scoreboard compares every status word and slot against values built from R5 to R7.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;
  localparam int IDX_W = 15;
  localparam int NCOLL_W = 5;

  typedef struct packed {
    logic               ok;
    logic               lcrs;
    logic               ow;
    logic               txu;
    logic               ecoll;
    logic [NCOLL_W-1:0] ncoll;
  } tx_result_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_KICK,
    S_WAIT,
    S_STAT
  } ring_state_t;

  // Status layout: 31 done, 30 good, 29 abort, 28 carrier, 26 window,
  // 25 underrun, 24 excess, 20:16 collisions, 14:0 echoed index.
  function automatic logic [31:0] pack_status(input logic aborted,
                                              input logic [IDX_W-1:0] idx,
                                              input tx_result_t r);
    logic [31:0] w;
    w = '0;
    w[31] = 1'b1;
    w[29] = aborted;
    w[14:0] = idx;
    if (!aborted) begin
      w[30] = r.ok;
      w[28] = r.lcrs;
      w[26] = r.ow;
      w[25] = r.txu;
      w[24] = r.ecoll;
      w[20:16] = r.ncoll;
    end
    return w;
  endfunction
endpackage

// File: rtl/tx_pend_ctr.sv
module tx_pend_ctr #(
  parameter int RING_ENTRIES = 8,
  localparam int CNT_W = $clog2(RING_ENTRIES + 1),
  localparam int SUM_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_we,
  input  logic [CNT_W-1:0] enq_cnt,
  input  logic             dec,
  output logic [CNT_W-1:0] pending,
  output logic             ovf_err
);
  logic [CNT_W-1:0] pend_d;
  logic             err_d;
  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = SUM_W'(pending) + (enq_we ? SUM_W'(enq_cnt) : '0) - SUM_W'(dec);
    err_d = ovf_err;
    if (sum > SUM_W'(RING_ENTRIES)) begin
      pend_d = CNT_W'(RING_ENTRIES);
      err_d = 1'b1;
    end else begin
      pend_d = sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
      ovf_err <= 1'b0;
    end else begin
      pending <= pend_d;
      ovf_err <= err_d;
    end
  end
endmodule

// File: rtl/tx_irq_reg.sv
module tx_irq_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic en,
  output logic irq
);
  logic sts_q, sts_d;

  always_comb begin
    sts_d = sts_q;
    if (clr) sts_d = 1'b0;
    if (set) sts_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= 1'b0;
    else        sts_q <= sts_d;
  end

  assign irq = sts_q & en;
endmodule

// File: rtl/tx_ring_fsm.sv
module tx_ring_fsm
  import tx_ring_pkg::*;
#(
  parameter int RING_ENTRIES = 8,
  localparam int PTR_W = $clog2(RING_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  output logic             desc_rd,
  output logic [PTR_W-1:0] desc_addr,
  input  logic [31:0]      desc_rdata_addr,
  input  logic [31:0]      desc_rdata_ctl,
  output logic             core_start,
  output logic [31:0]      core_buf_addr,
  output logic [11:0]      core_len,
  output logic             core_eof,
  input  logic             core_done,
  input  tx_result_t       core_res,
  output logic             st_we,
  output logic [PTR_W-1:0] st_addr,
  output logic [31:0]      st_wdata
);
  ring_state_t      state_q, state_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [31:0]      addr_q;
  logic [11:0]      len_q;
  logic             eof_q, abort_q;
  logic [IDX_W-1:0] idx_q;
  tx_result_t       res_q;
  logic             load_en, res_en;
  logic             unused_ctl_bits;

  assign unused_ctl_bits = ^desc_rdata_ctl[14:12];

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    load_en = 1'b0;
    res_en  = 1'b0;
    unique case (state_q)
      S_IDLE: if (go) state_d = S_LOAD;
      S_LOAD: begin
        load_en = 1'b1;
        state_d = desc_rdata_ctl[15] ? S_STAT : S_KICK;
      end
      S_KICK: state_d = S_WAIT;
      S_WAIT: if (core_done) begin
        res_en  = 1'b1;
        state_d = S_STAT;
      end
      S_STAT: begin
        ptr_d   = ptr_q + PTR_W'(1);
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      len_q   <= '0;
      eof_q   <= 1'b0;
      abort_q <= 1'b0;
      idx_q   <= '0;
    end else if (load_en) begin
      addr_q  <= desc_rdata_addr;
      len_q   <= desc_rdata_ctl[11:0];
      eof_q   <= desc_rdata_ctl[31];
      abort_q <= desc_rdata_ctl[15];
      idx_q   <= desc_rdata_ctl[30:16];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (res_en) res_q <= core_res;
  end

  assign desc_rd       = (state_q == S_IDLE) && go;
  assign desc_addr     = ptr_q;
  assign core_start    = (state_q == S_KICK);
  assign core_buf_addr = addr_q;
  assign core_len      = len_q;
  assign core_eof      = eof_q;
  assign st_we         = (state_q == S_STAT);
  assign st_addr       = ptr_q;
  assign st_wdata      = pack_status(abort_q, idx_q, res_q);
endmodule

// File: rtl/tx_ring_engine.sv
module tx_ring_engine
  import tx_ring_pkg::*;
#(
  parameter int RING_ENTRIES = 8,
  localparam int PTR_W = $clog2(RING_ENTRIES),
  localparam int CNT_W = $clog2(RING_ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             dma_en,
  input  logic             enq_we,
  input  logic [CNT_W-1:0] enq_cnt,
  output logic             desc_rd,
  output logic [PTR_W-1:0] desc_addr,
  input  logic [31:0]      desc_rdata_addr,
  input  logic [31:0]      desc_rdata_ctl,
  output logic             core_start,
  output logic [31:0]      core_buf_addr,
  output logic [11:0]      core_len,
  output logic             core_eof,
  input  logic             core_done,
  input  logic             core_ok,
  input  logic             core_lcrs,
  input  logic             core_ow,
  input  logic             core_txu,
  input  logic             core_ecoll,
  input  logic [4:0]       core_ncoll,
  output logic             st_we,
  output logic [PTR_W-1:0] st_addr,
  output logic [31:0]      st_wdata,
  input  logic             irq_en,
  input  logic             irq_clr,
  output logic             irq,
  output logic [CNT_W-1:0] pending,
  output logic             ovf_err
);
  tx_result_t res;
  logic       go;

  assign res = '{ok: core_ok, lcrs: core_lcrs, ow: core_ow, txu: core_txu,
                 ecoll: core_ecoll, ncoll: core_ncoll};
  assign go = tx_en && dma_en && (pending != '0);

  tx_pend_ctr #(.RING_ENTRIES(RING_ENTRIES)) u_ctr (
    .clk(clk), .rst_n(rst_n), .enq_we(enq_we), .enq_cnt(enq_cnt),
    .dec(st_we), .pending(pending), .ovf_err(ovf_err)
  );

  tx_ring_fsm #(.RING_ENTRIES(RING_ENTRIES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .go(go),
    .desc_rd(desc_rd), .desc_addr(desc_addr),
    .desc_rdata_addr(desc_rdata_addr), .desc_rdata_ctl(desc_rdata_ctl),
    .core_start(core_start), .core_buf_addr(core_buf_addr),
    .core_len(core_len), .core_eof(core_eof),
    .core_done(core_done), .core_res(res),
    .st_we(st_we), .st_addr(st_addr), .st_wdata(st_wdata)
  );

  tx_irq_reg u_irq (
    .clk(clk), .rst_n(rst_n), .set(st_we), .clr(irq_clr),
    .en(irq_en), .irq(irq)
  );
endmodule

// File: rtl/tx_ring_engine_chk.sv
module tx_ring_engine_chk #(
  parameter int RING_ENTRIES = 8,
  localparam int CNT_W = $clog2(RING_ENTRIES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             dma_en,
  input logic             enq_we,
  input logic             desc_rd,
  input logic             core_start,
  input logic             st_we,
  input logic [31:0]      st_wdata,
  input logic             irq_en,
  input logic             irq,
  input logic [CNT_W-1:0] pending,
  input logic             ovf_err
);
  logic unused_status_bits;
  assign unused_status_bits = ^st_wdata[28:0];

  AST_PEND_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    st_we && !enq_we |=> pending == $past(pending) - CNT_W'(1)); // R1
  AST_PEND_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    pending <= CNT_W'(RING_ENTRIES)); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err); // R2
  AST_FETCH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    desc_rd |-> tx_en && dma_en && pending != '0); // R3
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start); // R4
  AST_STATUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> st_wdata[31]); // R5
  AST_ABORT_NOT_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    st_we && st_wdata[29] |-> !st_wdata[30]); // R6
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    st_we && irq_en |=> irq || !irq_en); // R8
endmodule

bind tx_ring_engine tx_ring_engine_chk #(.RING_ENTRIES(RING_ENTRIES)) u_chk (.*);

// File: tb/tx_ring_engine_test.sv
module tx_ring_engine_test;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        tx_en, dma_en, enq_we;
  logic [3:0]  enq_cnt;
  logic        desc_rd;
  logic [2:0]  desc_addr;
  logic [31:0] desc_rdata_addr, desc_rdata_ctl;
  logic        core_start;
  logic [31:0] core_buf_addr;
  logic [11:0] core_len;
  logic        core_eof;
  logic        core_done, core_ok, core_lcrs, core_ow, core_txu, core_ecoll;
  logic [4:0]  core_ncoll;
  logic        st_we;
  logic [2:0]  st_addr;
  logic [31:0] st_wdata;
  logic        irq_en, irq_clr, irq;
  logic [3:0]  pending;
  logic        ovf_err;

  tx_ring_engine uut (.*);

  int vectors = 0;
  int errors = 0;
  int rd_seen = 0;
  int starts_seen = 0;
  int wp = 0;

  logic [31:0] mem_addr [8];
  logic [31:0] mem_ctl  [8];
  logic [9:0]  core_q [$];
  logic [34:0] exp_st_q [$];
  logic [44:0] exp_start_q [$];

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // descriptor memory with one-cycle read latency
  always @(posedge clk) begin
    if (desc_rd) begin
      desc_rdata_addr <= mem_addr[desc_addr];
      desc_rdata_ctl  <= mem_ctl[desc_addr];
    end
  end

  // transmit core model: result three cycles after start
  int busy = 0;
  always @(posedge clk) begin
    core_done <= 1'b0;
    if (core_start) begin
      logic [9:0] r;
      r = core_q.pop_front();
      {core_ok, core_lcrs, core_ow, core_txu, core_ecoll, core_ncoll} <= r;
      busy = 3;
    end else if (busy > 0) begin
      busy--;
      if (busy == 0) core_done <= 1'b1;
    end
  end

  // monitor: status writes and core starts against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (desc_rd) rd_seen++;
      if (core_start) begin
        starts_seen++;
        if (exp_start_q.size() == 0) check("R4 unexpected start", 64'(core_start), 64'd0);
        else check("R4 core fields", 64'({core_buf_addr, core_len, core_eof}),
                   64'(exp_start_q.pop_front()));
      end
      if (st_we) begin
        if (exp_st_q.size() == 0) check("R7 unexpected status", 64'(st_we), 64'd0);
        else check("R5 R6 R7 status slot/word", 64'({st_addr, st_wdata}),
                   64'(exp_st_q.pop_front()));
      end
    end
  end

  // builds the descriptor at the software pointer and the expected results
  task automatic post(input logic [14:0] idx, input logic [11:0] len, input logic eof,
                      input logic ab, input logic [9:0] res);
    logic [31:0] ctl, st, a;
    a = 32'h1000_0000 + 32'(wp) * 32'h800 + 32'(idx);
    ctl = {eof, idx, ab, 3'b000, len};
    mem_addr[wp] = a;
    mem_ctl[wp] = ctl;
    if (ab) st = {1'b1, 1'b0, 1'b1, 13'b0, 1'b0, idx};
    else begin
      st = {1'b1, res[9], 1'b0, res[8], 1'b0, res[7], res[6], res[5], 3'b000,
            res[4:0], 1'b0, idx};
      core_q.push_back(res);
      exp_start_q.push_back({a, len, eof});
    end
    exp_st_q.push_back({3'(wp), st});
    wp = (wp + 1) % 8;
  endtask

  task automatic enqueue(input int n);
    @(negedge clk);
    enq_we = 1'b1;
    enq_cnt = 4'(n);
    @(negedge clk);
    enq_we = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && (exp_st_q.size() != 0 || pending != 0); i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 60000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tx_en = 1'b0; dma_en = 1'b0; enq_we = 1'b0; enq_cnt = '0;
    irq_en = 1'b0; irq_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 pending reset", 64'(pending), 64'd0);
    check("R9 flags reset", 64'({ovf_err, irq, desc_rd, st_we}), 64'd0);

    // R3: DMA disabled holds the work
    tx_en = 1'b1;
    post(15'h0011, 12'd64, 1'b1, 1'b0, {1'b1, 4'b0, 5'd0});
    enqueue(1);
    repeat (10) @(negedge clk);
    check("R3 no fetch while dma off", 64'(rd_seen), 64'd0);
    check("R3 pending held", 64'(pending), 64'd1);
    irq_en = 1'b1;
    dma_en = 1'b1;
    drain();
    check("R1 pending back to zero", 64'(pending), 64'd0);
    check("R8 irq after status", 64'(irq), 64'd1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    check("R8 irq cleared", 64'(irq), 64'd0);

    // mixed results, abort, batch enqueue
    post(15'h7fff, 12'd1514, 1'b1, 1'b0, {1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 5'd16});
    enqueue(1);
    starts_seen = 0;
    post(15'h0203, 12'd100, 1'b0, 1'b1, 10'h3ff);
    post(15'h0004, 12'hfff, 1'b1, 1'b0, {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd3});
    post(15'h1234, 12'd60, 1'b1, 1'b1, 10'h000);
    enqueue(3);
    drain();
    check("R6 aborted descriptors not started", 64'(starts_seen), 64'd2);

    // R1/R8: completion coinciding with enqueue, later with irq clear
    post(15'h0051, 12'd80, 1'b1, 1'b0, {1'b1, 4'b0, 5'd1});
    post(15'h0052, 12'd81, 1'b1, 1'b0, {1'b1, 4'b0, 5'd2});
    enqueue(1);
    for (int i = 0; i < 100 && !st_we; i++) @(negedge clk);
    enq_we = 1'b1; enq_cnt = 4'd1;
    @(negedge clk);
    enq_we = 1'b0;
    check("R1 enqueue and completion same cycle", 64'(pending), 64'd1);
    for (int i = 0; i < 100 && !st_we; i++) @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    check("R8 set wins over clear", 64'(irq), 64'd1);
    drain();

    // R2/R7: saturation and pointer wrap
    tx_en = 1'b0;
    for (int k = 0; k < 8; k++)
      post(15'(16'h0100 + 16'(k)), 12'(200 + k), 1'(k % 2), 1'(k == 5), {1'b1, 4'b0, 5'(k)});
    enqueue(5);
    check("R2 no error below limit", 64'(ovf_err), 64'd0);
    enqueue(5);
    check("R2 pending saturates", 64'(pending), 64'd8);
    check("R2 overflow flag", 64'(ovf_err), 64'd1);
    tx_en = 1'b1;
    drain();
    check("R7 all slots drained", 64'(exp_st_q.size()), 64'd0);
    check("R2 flag sticky", 64'(ovf_err), 64'd1);
    check("R1 pending empty", 64'(pending), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule